// File: doc/BRIEF.md
# Programmable SRAM Bus Wait-State Controller

This block turns a one-cycle internal access request into the strobe sequence for a single external SRAM area, on the bus clock. A request carries an address, a direction flag and write data. Once accepted, the controller drives the bus through a fixed order of phases: an optional setup cycle, the address cycle (T1), a programmable run of access waits, the strobe-end cycle (T2) and a programmable run of hold cycles. The address and chip select stay steady for the whole access.

Timing comes from static configuration inputs, which are captured when a request is accepted: a setup enable (0 or 1 cycle), an access wait count (0 to 15), a hold count (0 to 3), a read-hold bit that moves the read strobe's negation one cycle later, and a byte-control mode flag that forces the read-hold bit off. On a read, the controller captures the bus data at the end of T2. It then signals completion with a one-cycle done pulse after the last hold cycle. Requests are accepted only while the controller is idle, and the idle state is shown on a ready output.

Top module: `sram_wait_ctrl`

## Requirements
- R1: After reset, busCsN, busRdN and busStartN are 1, busRdWr is 1, busDoutEn and rspDone are 0, and reqReady is 1.
- R2: An accepted request holds busCsN low for exactly setup + 1 + wait + 1 + hold consecutive cycles, where setup is cfgSetup (0 or 1), wait is cfgAccWait (0..15) and hold is cfgHold (0..3). For example, 1, 3 and 2 give 8 cycles.
- R3: With cfgSetup = 1, busCsN is low for one cycle before the T1 cycle. With cfgSetup = 0, T1 is the first cycle of the access.
- R4: busStartN is low for exactly one cycle of each access, and that cycle is T1.
- R5: On a read with the effective read-hold off, busRdN is low from T1 through T2, which is 2 + wait cycles.
- R6: On a read with cfgRdHold = 1 and hold >= 1, busRdN stays low for one more cycle, through the first hold cycle. With hold = 0 there is no extension.
- R7: When cfgByteCtl = 1, the read strobe behaves as though cfgRdHold were 0, whatever cfgRdHold holds.
- R8: rspRdata takes the value of busDin sampled at the clock edge that ends T2 of a read.
- R9: rspDone is high for exactly one cycle, the cycle right after the last cycle with busCsN low.
- R10: On a write, busDoutEn is high from T1 through the last hold cycle, busDout carries the request's write data, busRdWr is 0 throughout the access, and busRdN stays 1.
- R11: On a read, busRdWr is 1 throughout the access. busAddr holds the request's address for every cycle that busCsN is low.
- R12: reqReady is 0 while an access is in progress. A reqValid during an access is ignored and starts no further access. Configuration changes after acceptance do not alter the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | One-cycle access request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | AW | Access address |
| reqWdata | input | DW | Write data |
| reqReady | output | 1 | High when idle and able to accept |
| cfgSetup | input | 1 | Setup cycle enable |
| cfgAccWait | input | WAIT_W | Access wait count |
| cfgHold | input | HOLD_W | Hold cycle count |
| cfgRdHold | input | 1 | Delay read strobe negation by one hold cycle |
| cfgByteCtl | input | 1 | Byte-control mode; forces read-hold off |
| busAddr | output | AW | Address to SRAM |
| busCsN | output | 1 | Chip select, active low |
| busRdWr | output | 1 | 1 = read, 0 = write |
| busRdN | output | 1 | Read strobe, active low |
| busStartN | output | 1 | Bus-start marker, active low in T1 |
| busDout | output | DW | Write data to SRAM |
| busDoutEn | output | 1 | Write data driver enable |
| busDin | input | DW | Read data from SRAM |
| rspDone | output | 1 | Access-complete pulse |
| rspRdata | output | DW | Captured read data |

## Verification
The checker watches the per-cycle relations on every cycle. These are the single-cycle bus-start and done pulses, done appearing when chip select rises, an idle read strobe and data driver, the absence of a read strobe on writes, a steady address under chip select, and the ready output being low during an access. Several behaviours depend on the configured counts and need the bench's directed scenarios: the total access length, the position of T1, the exact length of the read strobe with and without the read-hold extension, the byte-control override, the data captured at the end of T2, and the proof that a mid-access request or configuration change has no effect.

// File: rtl/sramw_pkg.sv
package sramw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_T1,
    ST_WAIT,
    ST_T2,
    ST_HOLD
  } busState_t;

  typedef struct packed {
    logic accept;
    logic loadWait;
    logic loadHold;
    logic countDown;
    logic capture;
  } dpCtl_t;
endpackage

// File: rtl/sramw_dp.sv
module sramw_dp
  import sramw_pkg::*;
#(
  parameter int AW = 26,
  parameter int DW = 32,
  parameter int WAIT_W = 4,
  parameter int HOLD_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              reqWrite,
  input  logic [AW-1:0]     reqAddr,
  input  logic [DW-1:0]     reqWdata,
  input  logic [WAIT_W-1:0] cfgAccWait,
  input  logic [HOLD_W-1:0] cfgHold,
  input  logic              cfgRdHold,
  input  logic              cfgByteCtl,
  input  logic [DW-1:0]     busDin,
  output logic [AW-1:0]     addrQ,
  output logic [DW-1:0]     wdataQ,
  output logic              isWrite,
  output logic              rdHoldEff,
  output logic              waitZero,
  output logic              holdZero,
  output logic              cntLast,
  output logic              firstHold,
  output logic [DW-1:0]     rdataQ
);
  localparam int CNT_W = (WAIT_W > HOLD_W) ? WAIT_W : HOLD_W;

  logic [WAIT_W-1:0] waitQ;
  logic [HOLD_W-1:0] holdQ;
  logic [CNT_W-1:0]  cnt;

  // Request and configuration capture at acceptance
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ     <= '0;
      wdataQ    <= '0;
      isWrite   <= 1'b0;
      rdHoldEff <= 1'b0;
      waitQ     <= '0;
      holdQ     <= '0;
    end else if (ctl.accept) begin
      addrQ     <= reqAddr;
      wdataQ    <= reqWdata;
      isWrite   <= reqWrite;
      rdHoldEff <= cfgRdHold & ~cfgByteCtl;
      waitQ     <= cfgAccWait;
      holdQ     <= cfgHold;
    end
  end

  // Shared phase counter for access waits and hold cycles
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.loadWait) begin
      cnt <= CNT_W'(waitQ);
    end else if (ctl.loadHold) begin
      cnt <= CNT_W'(holdQ);
    end else if (ctl.countDown) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  // Read data capture at the end of T2
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdataQ <= '0;
    end else if (ctl.capture) begin
      rdataQ <= busDin;
    end
  end

  assign waitZero  = (waitQ == '0);
  assign holdZero  = (holdQ == '0);
  assign cntLast   = (cnt == CNT_W'(1));
  assign firstHold = (cnt == CNT_W'(holdQ));
endmodule

// File: rtl/sramw_ctrl.sv
module sramw_ctrl
  import sramw_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   cfgSetup,
  input  logic   isWrite,
  input  logic   rdHoldEff,
  input  logic   waitZero,
  input  logic   holdZero,
  input  logic   cntLast,
  input  logic   firstHold,
  output dpCtl_t ctl,
  output logic   reqReady,
  output logic   busCsN,
  output logic   busRdWr,
  output logic   busRdN,
  output logic   busStartN,
  output logic   busDoutEn,
  output logic   rspDone
);
  busState_t state, stateNext;
  logic      doneNext;

  always_comb begin
    stateNext = state;
    ctl       = '0;
    doneNext  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.accept = 1'b1;
          stateNext  = cfgSetup ? ST_SETUP : ST_T1;
        end
      end
      ST_SETUP: stateNext = ST_T1;
      ST_T1: begin
        if (waitZero) begin
          stateNext = ST_T2;
        end else begin
          ctl.loadWait = 1'b1;
          stateNext    = ST_WAIT;
        end
      end
      ST_WAIT: begin
        ctl.countDown = 1'b1;
        if (cntLast) stateNext = ST_T2;
      end
      ST_T2: begin
        ctl.capture = ~isWrite;
        if (holdZero) begin
          doneNext  = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          ctl.loadHold = 1'b1;
          stateNext    = ST_HOLD;
        end
      end
      ST_HOLD: begin
        ctl.countDown = 1'b1;
        if (cntLast) begin
          doneNext  = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      rspDone <= 1'b0;
    end else begin
      state   <= stateNext;
      rspDone <= doneNext;
    end
  end

  logic active, strobePhase, dataPhase;
  assign active      = (state != ST_IDLE);
  assign strobePhase = (state == ST_T1) || (state == ST_WAIT) || (state == ST_T2);
  assign dataPhase   = strobePhase || (state == ST_HOLD);

  assign reqReady  = ~active;
  assign busCsN    = ~active;
  assign busRdWr   = ~(active & isWrite);
  assign busStartN = ~(state == ST_T1);
  assign busDoutEn = dataPhase & isWrite;
  assign busRdN    = ~(~isWrite & (strobePhase |
                       ((state == ST_HOLD) & rdHoldEff & firstHold)));
endmodule

// File: rtl/sram_wait_ctrl.sv
module sram_wait_ctrl
  import sramw_pkg::*;
#(
  parameter int AW = 26,
  parameter int DW = 32,
  parameter int WAIT_W = 4,
  parameter int HOLD_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [AW-1:0]     reqAddr,
  input  logic [DW-1:0]     reqWdata,
  output logic              reqReady,
  input  logic              cfgSetup,
  input  logic [WAIT_W-1:0] cfgAccWait,
  input  logic [HOLD_W-1:0] cfgHold,
  input  logic              cfgRdHold,
  input  logic              cfgByteCtl,
  output logic [AW-1:0]     busAddr,
  output logic              busCsN,
  output logic              busRdWr,
  output logic              busRdN,
  output logic              busStartN,
  output logic [DW-1:0]     busDout,
  output logic              busDoutEn,
  input  logic [DW-1:0]     busDin,
  output logic              rspDone,
  output logic [DW-1:0]     rspRdata
);
  dpCtl_t ctl;
  logic   isWrite, rdHoldEff, waitZero, holdZero, cntLast, firstHold;

  sramw_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .cfgSetup  (cfgSetup),
    .isWrite   (isWrite),
    .rdHoldEff (rdHoldEff),
    .waitZero  (waitZero),
    .holdZero  (holdZero),
    .cntLast   (cntLast),
    .firstHold (firstHold),
    .ctl       (ctl),
    .reqReady  (reqReady),
    .busCsN    (busCsN),
    .busRdWr   (busRdWr),
    .busRdN    (busRdN),
    .busStartN (busStartN),
    .busDoutEn (busDoutEn),
    .rspDone   (rspDone)
  );

  sramw_dp #(
    .AW(AW), .DW(DW), .WAIT_W(WAIT_W), .HOLD_W(HOLD_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqWrite   (reqWrite),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .cfgAccWait (cfgAccWait),
    .cfgHold    (cfgHold),
    .cfgRdHold  (cfgRdHold),
    .cfgByteCtl (cfgByteCtl),
    .busDin     (busDin),
    .addrQ      (busAddr),
    .wdataQ     (busDout),
    .isWrite    (isWrite),
    .rdHoldEff  (rdHoldEff),
    .waitZero   (waitZero),
    .holdZero   (holdZero),
    .cntLast    (cntLast),
    .firstHold  (firstHold),
    .rdataQ     (rspRdata)
  );
endmodule

// File: rtl/sramw_chk.sv
module sramw_chk #(
  parameter int AW = 26
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqReady,
  input logic [AW-1:0] busAddr,
  input logic          busCsN,
  input logic          busRdWr,
  input logic          busRdN,
  input logic          busStartN,
  input logic          busDoutEn,
  input logic          rspDone
);
  a_r4_start_single: assert property (@(posedge clk) disable iff (!rstN)
    !busStartN |=> busStartN);
  a_r4_start_in_access: assert property (@(posedge clk) disable iff (!rstN)
    !busStartN |-> !busCsN);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);
  a_r9_done_after_cs: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busCsN) |-> rspDone);
  a_r10_no_rd_on_write: assert property (@(posedge clk) disable iff (!rstN)
    !busRdWr |-> busRdN);
  a_r10_dout_only_write: assert property (@(posedge clk) disable iff (!rstN)
    busDoutEn |-> (!busRdWr && !busCsN));
  a_r11_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!busCsN && $past(!busCsN)) |-> $stable(busAddr));
  a_r12_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    !busCsN |-> !reqReady);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    busCsN |-> (busRdN && busStartN && !busDoutEn));
endmodule

bind sram_wait_ctrl sramw_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqReady  (reqReady),
  .busAddr   (busAddr),
  .busCsN    (busCsN),
  .busRdWr   (busRdWr),
  .busRdN    (busRdN),
  .busStartN (busStartN),
  .busDoutEn (busDoutEn),
  .rspDone   (rspDone)
);

// File: tb/sim_sram_wait_ctrl.sv
`timescale 1ns/1ps
module sim_sram_wait_ctrl;
  localparam int AW = 26;
  localparam int DW = 32;
  localparam logic [DW-1:0] PAT = 32'hA55A_0000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic          reqReady;
  logic          cfgSetup = 1'b0;
  logic [3:0]    cfgAccWait = '0;
  logic [1:0]    cfgHold = '0;
  logic          cfgRdHold = 1'b0, cfgByteCtl = 1'b0;
  logic [AW-1:0] busAddr;
  logic          busCsN, busRdWr, busRdN, busStartN, busDoutEn;
  logic [DW-1:0] busDout;
  logic [DW-1:0] busDin = '0;
  logic          rspDone;
  logic [DW-1:0] rspRdata;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  sram_wait_ctrl u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .cfgSetup(cfgSetup), .cfgAccWait(cfgAccWait), .cfgHold(cfgHold),
    .cfgRdHold(cfgRdHold), .cfgByteCtl(cfgByteCtl), .busAddr(busAddr),
    .busCsN(busCsN), .busRdWr(busRdWr), .busRdN(busRdN),
    .busStartN(busStartN), .busDout(busDout), .busDoutEn(busDoutEn),
    .busDin(busDin), .rspDone(rspDone), .rspRdata(rspRdata)
  );

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doAccess(input bit wr, input logic [AW-1:0] addr,
                          input logic [DW-1:0] wdata, input int setup,
                          input int waitN, input int hold, input bit rdHold,
                          input bit byteCtl, input bit inject);
    int csCnt = 0, startCnt = 0, startIdx = -1, rdCnt = 0, rdFirst = -1;
    int enCnt = 0, enFirst = -1, doneIdx = -1, readyBusy = 0;
    int rdWrBad = 0, addrBad = 0, doutBad = 0;
    int total, rdExp;
    logic [DW-1:0] rdataExp;
    string rdReq;
    @(negedge clk);
    chk("R12", "ready before request", reqReady, 1);
    reqWrite = wr; reqAddr = addr; reqWdata = wdata;
    cfgSetup = setup[0]; cfgAccWait = waitN[3:0]; cfgHold = hold[1:0];
    cfgRdHold = rdHold; cfgByteCtl = byteCtl;
    reqValid = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (k == 0) begin
        reqValid = 1'b0;
        if (inject) begin
          cfgSetup = ~cfgSetup; cfgAccWait = ~cfgAccWait;
          cfgHold = ~cfgHold; cfgRdHold = ~cfgRdHold; cfgByteCtl = ~cfgByteCtl;
        end
      end
      if (inject && k == 2) begin
        reqValid = 1'b1; reqAddr = ~addr; reqWrite = ~wr; reqWdata = ~wdata;
      end
      if (inject && k == 3) reqValid = 1'b0;
      if (!busCsN) begin
        if (!busStartN) begin startCnt++; startIdx = csCnt; end
        if (!busRdN) begin if (rdFirst < 0) rdFirst = csCnt; rdCnt++; end
        if (busDoutEn) begin if (enFirst < 0) enFirst = csCnt; enCnt++; end
        if (busRdWr != !wr) rdWrBad++;
        if (busAddr != addr) addrBad++;
        if (wr && busDout != wdata) doutBad++;
        if (reqReady) readyBusy++;
        busDin = PAT ^ DW'(csCnt);
        csCnt++;
      end
      if (rspDone) begin doneIdx = k; break; end
    end
    total = setup + 2 + waitN + hold;
    chk(inject ? "R12" : "R2", "access length", csCnt, total);
    chk("R3", "T1 position", startIdx, setup);
    chk("R4", "bus-start cycles", startCnt, 1);
    chk("R9", "done cycle", doneIdx, total);
    chk("R11", "address stable", addrBad, 0);
    chk("R12", "ready low while busy", readyBusy, 0);
    if (wr) begin
      chk("R10", "read strobe on write", rdCnt, 0);
      chk("R10", "driver enable cycles", enCnt, 1 + waitN + 1 + hold);
      chk("R10", "driver enable start", enFirst, setup);
      chk("R10", "direction low on write", rdWrBad, 0);
      chk("R10", "write data", doutBad, 0);
    end else begin
      rdExp = 2 + waitN;
      rdReq = "R5";
      if (rdHold && byteCtl) rdReq = "R7";
      else if (rdHold) rdReq = "R6";
      if (rdHold && !byteCtl && hold > 0) rdExp++;
      chk(rdReq, "read strobe cycles", rdCnt, rdExp);
      chk(rdReq, "read strobe start", rdFirst, setup);
      chk("R10", "no driver on read", enCnt, 0);
      chk("R11", "direction high on read", rdWrBad, 0);
      rdataExp = PAT ^ DW'(setup + 1 + waitN);
      chk("R8", "read data", rspRdata, rdataExp);
    end
    @(negedge clk);
    chk("R9", "done is one cycle", rspDone, 0);
    chk(inject ? "R12" : "R9", "no further access", busCsN, 1);
    chk("R12", "ready after done", reqReady, 1);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "csN", busCsN, 1);
    chk("R1", "rdN", busRdN, 1);
    chk("R1", "startN", busStartN, 1);
    chk("R1", "rdWr", busRdWr, 1);
    chk("R1", "doutEn", busDoutEn, 0);
    chk("R1", "done", rspDone, 0);
    chk("R1", "ready", reqReady, 1);
  endtask

  initial begin : watchdog
    #1ms;
    fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    testReset();
    doAccess(1'b0, 26'h0123456, '0, 1, 3, 2, 1'b0, 1'b0, 1'b0);   // 8-cycle example
    doAccess(1'b0, 26'h0000010, '0, 0, 0, 0, 1'b0, 1'b0, 1'b0);   // shortest read
    doAccess(1'b0, 26'h2AAAAAA, '0, 0, 2, 2, 1'b1, 1'b0, 1'b0);   // R6 extension
    doAccess(1'b0, 26'h1555555, '0, 1, 1, 2, 1'b1, 1'b1, 1'b0);   // R7 override
    doAccess(1'b0, 26'h0F0F0F0, '0, 0, 4, 0, 1'b1, 1'b0, 1'b0);   // R6 with no hold
    doAccess(1'b1, 26'h3FFFFFF, 32'hDEADBEEF, 1, 15, 3, 1'b0, 1'b0, 1'b0);
    doAccess(1'b1, 26'h0000ABC, 32'h12345678, 0, 2, 1, 1'b0, 1'b0, 1'b1);
    doAccess(1'b0, 26'h0BEEF00, '0, 0, 5, 1, 1'b0, 1'b0, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule